// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Controller with Bus-Contention Fault

This block is a byte-wide serial peripheral (SPI) engine that works either as the clock-generating master or as a clocked slave on one shared set of pins: serial clock, master-out data, master-in data and a select input. A small control register sets the role, the clock idle level, the clock phase, open-drain signalling, the interrupt enable and the module enable. A separate fault-enable bit decides whether a master listens to the select input.

In the master role, a write of a data byte starts a transfer. The block produces sixteen serial clock edges, shifts the byte out most significant bit first and shifts the reply in. In the slave role, the select input frames the transfer, and the outgoing byte is taken from a transmit buffer. While select is high the slave lets its data output float, ignores clock edges and drops any partial byte. A master with the fault check turned on treats a low select as a sign that another master holds the bus. It then latches a fault, releases its clock and data drivers and refuses new transfers until software runs the clearing sequence.

The pads themselves are outside the block. Each output comes as a level plus an output enable, so that open-drain operation can be shown by releasing the enable instead of driving high.

Top module: `spi_fault_ctl`

## Requirements
- R1: ctrl_q shows the control register as last written through ctrl_we: bit 0 module enable, bit 1 master role, bit 2 clock idle level (cpol), bit 3 clock phase (cpha), bit 4 open-drain, bit 5 interrupt enable. After reset, ctrl_q, modf, rx_full and xfer_busy are all 0.
- R2: While the module enable bit is 0, sck_oe, mosi_oe and miso_oe are 0, ss_gpio is 1, and a data write starts no transfer.
- R3: ss_gpio is 0 (select owned by the block) only when the block is enabled and is either a slave or a master with the fault-enable bit set. Otherwise it is 1.
- R4: When an enabled master with no fault sees data_we, xfer_busy rises. The block then makes exactly 16 serial clock transitions spaced DIV_HALF clock cycles apart, and the serial clock rests at the cpol level when idle.
- R5: With cpha 0, data is captured on the first transition of each bit and changed on the second. With cpha 1, data is changed on the first transition and captured on the second. Bits travel most significant first in both roles.
- R6: After the eighth bit, rx_full goes to 1 and rx_data holds the received byte. rx_full stays 1 until a data_rd pulse clears it.
- R7: An enabled slave with ss_in at 1 has miso_oe at 0 in that same cycle.
- R8: An enabled slave ignores clock edges while select is high. Raising select in the middle of a byte discards the partial byte and reloads the transmit byte, so the next framed byte starts over.
- R9: In the cpha 1 slave role, select may stay low across several bytes. Each byte sends the transmit buffer value that was current when the previous byte completed.
- R10: An enabled master with fault-enable set that sees select low (after synchronization) sets modf, ends any transfer and drives sck_oe and mosi_oe to 0 for as long as modf is 1.
- R11: modf stays 1 until a stat_rd pulse is followed by a ctrl_we write. While modf is 1, data writes start no transfer.
- R12: irq is 1 exactly when the interrupt enable bit is 1 and modf or rx_full is 1.
- R13: With open-drain selected, sck_out, mosi_out and miso_out are always 0, and a high level is shown by its output enable being 0.
- R14: An enabled master with fault-enable clear ignores a low select: the transfer completes and modf stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe (also second step of fault clear) |
| ctrl_wdata | input | 6 | Control register write value |
| ctrl_q | output | 6 | Control register contents |
| fault_en_we | input | 1 | Fault-enable bit write strobe |
| fault_en_wdata | input | 1 | Fault-enable bit value |
| stat_rd | input | 1 | Status read strobe (first step of fault clear) |
| modf | output | 1 | Latched bus-contention fault |
| data_we | input | 1 | Data write: starts master transfer or loads slave transmit buffer |
| data_wdata | input | 8 | Byte to transmit |
| data_rd | input | 1 | Data read strobe, clears rx_full |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Received byte waiting |
| xfer_busy | output | 1 | Master transfer in progress |
| irq | output | 1 | Interrupt request |
| ss_in | input | 1 | Select pin input |
| ss_gpio | output | 1 | 1 when the select pin is left to general I/O |
| sck_in | input | 1 | Serial clock pin input (slave) |
| sck_out | output | 1 | Serial clock output level |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_in | input | 1 | Master-out line input (slave) |
| mosi_out | output | 1 | Master-out output level |
| mosi_oe | output | 1 | Master-out output enable |
| miso_in | input | 1 | Master-in line input (master) |
| miso_out | output | 1 | Master-in output level |
| miso_oe | output | 1 | Master-in output enable |

## Verification
Some rules can be judged from a single cycle or a pair of cycles, and the assertions check these on every cycle. They are: the quiet outputs while disabled, the floating slave output under a high select, the drivers released during a fault, the fault staying latched without a control write, no transfer starting under a fault, the idle clock level, the interrupt equation, the open-drain rule that a level is never driven high, and rx_full holding until read. Other behaviour plays out over whole bytes, and only the bench scenarios can show it. That covers the clock transition count and spacing, bit order and capture phase in all four clock modes, byte reception through a loopback line, a slave byte dropped when select rises early, multi-byte slave framing with the transmit buffer refilled, and the two-step fault clear.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
   localparam int CTRL_W = 6;
   localparam int NPINS  = 3;
   localparam int PIN_SCK  = 0;
   localparam int PIN_MOSI = 1;
   localparam int PIN_MISO = 2;

   // bit 0 enable ... bit 5 irq_en
   typedef struct packed {
      logic irq_en;
      logic odrain;
      logic cpha;
      logic cpol;
      logic master;
      logic enable;
   } ctrl_t;
endpackage

// File: rtl/spi_fault_sync.sv
module spi_fault_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RST;
            else        st[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RST;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/spi_fault_baud.sv
module spi_fault_baud #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_HALF - 1);

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_fault_shift.sv
module spi_fault_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld,
   input  logic [DATA_W-1:0] ld_val,
   input  logic              ev,
   input  logic              cpha,
   input  logic              din,
   output logic              dout,
   output logic              done,
   output logic [DATA_W-1:0] word
);
   localparam int EDGES = 2 * DATA_W;
   localparam int CW    = $clog2(EDGES);
   localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

   logic [CW-1:0]     cnt;
   logic [DATA_W-1:0] sh;
   logic              rbit;
   logic              lead, samp, skip;

   assign lead = ~cnt[0];
   assign samp = lead ^ cpha;
   assign skip = cpha && (cnt == '0);
   assign done = ev && !clr && (cnt == LAST);
   assign dout = sh[DATA_W-1];
   assign word = {sh[DATA_W-2:0], cpha ? din : rbit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sh   <= '0;
         rbit <= 1'b0;
      end else begin
         if (clr)      cnt <= '0;
         else if (ev)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;

         if (ld)                          sh <= ld_val;
         else if (ev && !samp && !skip)   sh <= {sh[DATA_W-2:0], rbit};

         if (ev && samp) rbit <= din;
      end
   end
endmodule

// File: rtl/spi_fault_pads.sv
module spi_fault_pads #(
   parameter int N = 3
) (
   input  logic         odrain,
   input  logic [N-1:0] drive,
   input  logic [N-1:0] level,
   output logic [N-1:0] pout,
   output logic [N-1:0] poe
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      assign pout[i] = odrain ? 1'b0 : level[i];
      assign poe[i]  = drive[i] && (odrain ? !level[i] : 1'b1);
   end
endmodule

// File: rtl/spi_fault_ctl.sv
module spi_fault_ctl #(
   parameter int DATA_W      = 8,
   parameter int DIV_HALF    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [5:0]        ctrl_wdata,
   output logic [5:0]        ctrl_q,
   input  logic              fault_en_we,
   input  logic              fault_en_wdata,
   input  logic              stat_rd,
   output logic              modf,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_wdata,
   input  logic              data_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              xfer_busy,
   output logic              irq,
   input  logic              ss_in,
   output logic              ss_gpio,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              mosi_in,
   output logic              mosi_out,
   output logic              mosi_oe,
   input  logic              miso_in,
   output logic              miso_out,
   output logic              miso_oe
);
   import spi_fault_pkg::*;

   if (DATA_W < 2)      begin : g_bad_w   $error("DATA_W must be at least 2"); end
   if (DIV_HALF < 2)    begin : g_bad_div $error("DIV_HALF must be at least 2"); end
   if (SYNC_STAGES < 2) begin : g_bad_syn $error("SYNC_STAGES must be at least 2"); end

   ctrl_t             ctrl;
   logic              fault_en, modf_r, clr_arm;
   logic              rx_full_r;
   logic [DATA_W-1:0] rx_r, txb;
   logic              m_act, sck_ph, sck_p;
   logic              ss_s, sck_s, mosi_s;
   logic              is_m, is_s, fault_hit, start, tick, s_edge, ev;
   logic              sh_clr, sh_ld, sh_dout, done;
   logic [DATA_W-1:0] sh_ld_val, word;
   logic [NPINS-1:0]  pdrive, plevel, pout, poe;

   spi_fault_sync #(.STAGES(SYNC_STAGES), .W(3), .RST(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ss_in, sck_in, mosi_in}),
      .q({ss_s, sck_s, mosi_s})
   );

   assign is_m      = ctrl.enable &&  ctrl.master;
   assign is_s      = ctrl.enable && !ctrl.master;
   assign ss_gpio   = !(ctrl.enable && (!ctrl.master || fault_en));
   assign fault_hit = is_m && fault_en && !ss_s;
   assign start     = data_we && is_m && !m_act && !modf_r && !fault_hit && !ctrl_we;
   assign s_edge    = is_s && !ss_s && (sck_s != sck_p);
   assign ev        = is_m ? tick : s_edge;

   spi_fault_baud #(.DIV_HALF(DIV_HALF)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(m_act), .tick(tick)
   );

   assign sh_clr    = !ctrl.enable || ctrl_we || fault_hit || (is_s && ss_s);
   assign sh_ld_val = data_we ? data_wdata : txb;

   spi_fault_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .clr(sh_clr), .ld(sh_ld), .ld_val(sh_ld_val),
      .ev(ev), .cpha(ctrl.cpha),
      .din(is_m ? miso_in : mosi_s),
      .dout(sh_dout), .done(done), .word(word)
   );

   assign sh_ld = start || (is_s && (ss_s || done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         fault_en  <= 1'b0;
         modf_r    <= 1'b0;
         clr_arm   <= 1'b0;
         rx_full_r <= 1'b0;
         rx_r      <= '0;
         txb       <= '0;
         m_act     <= 1'b0;
         sck_ph    <= 1'b0;
         sck_p     <= 1'b0;
      end else begin
         sck_p <= sck_s;
         if (ctrl_we)     ctrl     <= ctrl_t'(ctrl_wdata);
         if (fault_en_we) fault_en <= fault_en_wdata;
         if (data_we)     txb      <= data_wdata;

         // fault latch with read-then-write clear
         if (fault_hit) begin
            modf_r  <= 1'b1;
            clr_arm <= 1'b0;
         end else if (ctrl_we && clr_arm) begin
            modf_r  <= 1'b0;
            clr_arm <= 1'b0;
         end else if (stat_rd && modf_r) begin
            clr_arm <= 1'b1;
         end

         // master sequencing
         if (start) begin
            m_act  <= 1'b1;
            sck_ph <= 1'b0;
         end else if (!is_m || ctrl_we || fault_hit || (tick && done)) begin
            m_act  <= 1'b0;
            sck_ph <= 1'b0;
         end else if (tick) begin
            sck_ph <= ~sck_ph;
         end

         if (done)         rx_full_r <= 1'b1;
         else if (data_rd) rx_full_r <= 1'b0;
         if (done)         rx_r      <= word;
      end
   end

   assign pdrive[PIN_SCK]  = is_m && !modf_r;
   assign pdrive[PIN_MOSI] = is_m && !modf_r;
   assign pdrive[PIN_MISO] = is_s && !ss_in;
   assign plevel[PIN_SCK]  = ctrl.cpol ^ (m_act && sck_ph);
   assign plevel[PIN_MOSI] = sh_dout;
   assign plevel[PIN_MISO] = sh_dout;

   spi_fault_pads #(.N(NPINS)) u_pads (
      .odrain(ctrl.odrain), .drive(pdrive), .level(plevel),
      .pout(pout), .poe(poe)
   );

   assign sck_out   = pout[PIN_SCK];
   assign sck_oe    = poe[PIN_SCK];
   assign mosi_out  = pout[PIN_MOSI];
   assign mosi_oe   = poe[PIN_MOSI];
   assign miso_out  = pout[PIN_MISO];
   assign miso_oe   = poe[PIN_MISO];
   assign ctrl_q    = ctrl;
   assign modf      = modf_r;
   assign rx_full   = rx_full_r;
   assign rx_data   = rx_r;
   assign xfer_busy = m_act;
   assign irq       = ctrl.irq_en && (modf_r || rx_full_r);
endmodule

// File: rtl/spi_fault_chk.sv
module spi_fault_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [5:0] ctrl_q,
   input logic       ctrl_we,
   input logic       modf,
   input logic       xfer_busy,
   input logic       rx_full,
   input logic       data_rd,
   input logic       irq,
   input logic       ss_in,
   input logic       sck_out,
   input logic       sck_oe,
   input logic       mosi_out,
   input logic       mosi_oe,
   input logic       miso_out,
   input logic       miso_oe
);
   assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[0] |-> !(sck_oe || mosi_oe || miso_oe));

   assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && ctrl_q[1] && !ctrl_q[4] && !modf && !xfer_busy) |-> (sck_out == ctrl_q[2]));

   assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !data_rd) |=> rx_full);

   assert_miso_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && !ctrl_q[1] && ss_in) |-> !miso_oe);

   assert_fault_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      modf |-> (!sck_oe && !mosi_oe));

   assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (modf && !ctrl_we) |=> modf);

   assert_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_busy) |-> !$past(modf));

   assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl_q[5] && (modf || rx_full)));

   assert_irq_fault_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[5] && modf) |-> irq);

   assert_od_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[4] |-> (!sck_out && !mosi_out && !miso_out));
endmodule

bind spi_fault_ctl spi_fault_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .ctrl_we(ctrl_we),
   .modf(modf), .xfer_busy(xfer_busy), .rx_full(rx_full), .data_rd(data_rd),
   .irq(irq), .ss_in(ss_in),
   .sck_out(sck_out), .sck_oe(sck_oe), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
   .miso_out(miso_out), .miso_oe(miso_oe)
);

// File: tb/sim_spi_fault_ctl.sv
`timescale 1ns/1ps
module sim_spi_fault_ctl;
   localparam int HALF = 4;
   localparam int HB   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_we = 1'b0;
   logic [5:0] ctrl_wdata = '0;
   logic fault_en_we = 1'b0, fault_en_wdata = 1'b0, stat_rd = 1'b0;
   logic data_we = 1'b0, data_rd = 1'b0;
   logic [7:0] data_wdata = '0;
   logic ss_drv = 1'b1, sck_drv = 1'b0, mosi_drv = 1'b0;
   logic [5:0] ctrl_q;
   logic modf, rx_full, xfer_busy, irq, ss_gpio;
   logic [7:0] rx_data;
   logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
   wire  sck_line  = sck_oe  ? sck_out  : 1'b1;
   wire  mosi_line = mosi_oe ? mosi_out : 1'b1;
   wire  miso_line = miso_oe ? miso_out : 1'b1;
   wire  miso_in   = ~mosi_line;

   int total = 0, bad = 0, edges = 0, gap_bad = 0, od_bad = 0;
   time last_t = 0;
   bit finished = 0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   spi_fault_ctl u0 (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
      .fault_en_we(fault_en_we), .fault_en_wdata(fault_en_wdata), .stat_rd(stat_rd),
      .modf(modf), .data_we(data_we), .data_wdata(data_wdata), .data_rd(data_rd),
      .rx_data(rx_data), .rx_full(rx_full), .xfer_busy(xfer_busy), .irq(irq),
      .ss_in(ss_drv), .ss_gpio(ss_gpio), .sck_in(sck_drv), .sck_out(sck_out), .sck_oe(sck_oe),
      .mosi_in(mosi_drv), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
      .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // serial clock transition counter and spacing (R4)
   always @(sck_line) begin
      if (edges > 0 && ($time - last_t) != HALF * 10) gap_bad++;
      edges++;
      last_t = $time;
   end

   // open-drain monitor (R13)
   always @(negedge clk)
      if (rst_n && ctrl_q[4] && (sck_out || mosi_out || miso_out)) od_bad++;

   // scoreboard monitor (R6)
   always @(negedge clk) begin
      if (rst_n && rx_full && !data_rd) begin
         if (exp_q.size() == 0) chk(1'b0, "R6 unexpected byte", rx_data, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rx_data == e, "R6 rx_data", rx_data, e);
         end
         data_rd = 1'b1;
      end else data_rd = 1'b0;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      report();
   end

   task automatic tk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [5:0] v);
      ctrl_wdata = v; ctrl_we = 1'b1; tk(1); ctrl_we = 1'b0;
   endtask

   task automatic wr_fen(input logic v);
      fault_en_wdata = v; fault_en_we = 1'b1; tk(1); fault_en_we = 1'b0;
   endtask

   task automatic wr_data(input logic [7:0] v);
      data_wdata = v; data_we = 1'b1; tk(1); data_we = 1'b0;
   endtask

   task automatic m_xfer(input logic [7:0] tx, input logic cpol);
      int t;
      exp_q.push_back(~tx);
      edges = 0; gap_bad = 0;
      wr_data(tx);
      chk(xfer_busy == 1'b1, "R4 busy after write", xfer_busy, 1);
      t = 0;
      while (xfer_busy && t < 2000) begin tk(1); t++; end
      tk(3);
      chk(edges == 16, "R4 edge count", edges, 16);
      chk(gap_bad == 0, "R4 edge spacing", gap_bad, 0);
      chk(sck_line == cpol, "R4 idle level", sck_line, cpol);
   endtask

   task automatic s_xfer(input logic [7:0] tx, input int nbits, input logic cpol,
                         input logic cpha, output logic [7:0] cap);
      cap = '0;
      for (int i = 0; i < nbits; i++) begin
         if (!cpha) begin
            mosi_drv = tx[7-i];
            tk(HB);
            sck_drv = ~cpol;
            cap = {cap[6:0], miso_line};
            tk(HB);
            sck_drv = cpol;
         end else begin
            sck_drv = ~cpol;
            mosi_drv = tx[7-i];
            tk(HB);
            cap = {cap[6:0], miso_line};
            sck_drv = cpol;
            tk(HB);
         end
      end
      tk(HB);
   endtask

   initial begin
      logic [7:0] cap;
      tk(3);
      rst_n = 1'b1;
      tk(2);
      // reset state
      chk(ctrl_q == 6'h00, "R1 reset ctrl", ctrl_q, 0);
      chk(!modf && !rx_full && !xfer_busy, "R1 reset flags", {modf, rx_full, xfer_busy}, 0);
      // disabled
      wr_data(8'h55);
      tk(4);
      chk(xfer_busy == 1'b0, "R2 no start while off", xfer_busy, 0);
      chk({sck_oe, mosi_oe, miso_oe} == 3'b000, "R2 outputs released", {sck_oe, mosi_oe, miso_oe}, 0);
      chk(ss_gpio == 1'b1, "R2 select left to gpio", ss_gpio, 1);

      // master, all four clock modes, fault check off
      for (int m = 0; m < 4; m++) begin
         logic [5:0] cv;
         logic [7:0] tv;
         cv = 6'b000011 | 6'(m[0] << 2) | 6'(m[1] << 3);
         tv = 8'hB4 ^ 8'(m * 8'h3B);
         wr_ctrl(cv);
         tk(2);
         chk(ctrl_q == cv, "R1 ctrl readback", ctrl_q, cv);
         chk(ss_gpio == 1'b1, "R3 master without fault check", ss_gpio, 1);
         m_xfer(tv, m[0]); // R5 mode checked through loopback byte
      end

      // R14: low select ignored without fault check
      wr_ctrl(6'b000011);
      ss_drv = 1'b0;
      tk(4);
      m_xfer(8'h3A, 1'b0);
      chk(modf == 1'b0, "R14 no fault", modf, 0);
      ss_drv = 1'b1;
      tk(4);

      // mode fault
      wr_ctrl(6'b100011);
      wr_fen(1'b1);
      tk(2);
      chk(ss_gpio == 1'b0, "R3 master with fault check", ss_gpio, 0);
      wr_data(8'hF0);
      tk(5);
      ss_drv = 1'b0;
      tk(4);
      chk(modf == 1'b1, "R10 fault set", modf, 1);
      chk(!sck_oe && !mosi_oe, "R10 drivers released", {sck_oe, mosi_oe}, 0);
      chk(xfer_busy == 1'b0, "R10 transfer ended", xfer_busy, 0);
      chk(irq == 1'b1, "R12 fault irq", irq, 1);
      ss_drv = 1'b1;
      tk(4);
      chk(modf == 1'b1, "R11 fault sticky", modf, 1);
      wr_data(8'h11);
      tk(2);
      chk(xfer_busy == 1'b0, "R11 no start in fault", xfer_busy, 0);
      wr_ctrl(6'b100011);
      tk(1);
      chk(modf == 1'b1, "R11 write alone keeps fault", modf, 1);
      stat_rd = 1'b1; tk(1); stat_rd = 1'b0;
      wr_ctrl(6'b100011);
      tk(1);
      chk(modf == 1'b0, "R11 fault cleared", modf, 0);
      chk(irq == 1'b0, "R12 irq clear", irq, 0);
      m_xfer(8'h47, 1'b0);

      // open drain master
      wr_fen(1'b0);
      wr_ctrl(6'b011111);
      tk(2);
      chk(sck_oe == 1'b0 && sck_out == 1'b0, "R13 high idle released", {sck_oe, sck_out}, 0);
      m_xfer(8'h6D, 1'b1);
      wr_ctrl(6'b010011);
      tk(2);
      chk(sck_oe == 1'b1 && sck_out == 1'b0, "R13 low idle driven", {sck_oe, sck_out}, 2);
      m_xfer(8'h0F, 1'b0);
      chk(od_bad == 0, "R13 never drives high", od_bad, 0);

      // slave cpha 0
      wr_ctrl(6'b000001);
      sck_drv = 1'b0;
      tk(2);
      chk(ss_gpio == 1'b0, "R3 slave owns select", ss_gpio, 0);
      wr_data(8'h3C);
      tk(4);
      chk(miso_oe == 1'b0, "R7 float while deselected", miso_oe, 0);
      ss_drv = 1'b0;
      tk(HB);
      chk(miso_oe == 1'b1, "R7 drive when selected", miso_oe, 1);
      exp_q.push_back(8'hC6);
      s_xfer(8'hC6, 8, 1'b0, 1'b0, cap);
      chk(cap == 8'h3C, "R5 slave sends msb first", cap, 8'h3C);
      ss_drv = 1'b1;
      tk(4);

      // slave abort
      wr_data(8'h5A);
      ss_drv = 1'b0;
      tk(HB);
      s_xfer(8'hFF, 3, 1'b0, 1'b0, cap);
      ss_drv = 1'b1;
      #1;
      chk(miso_oe == 1'b0, "R7 float at once", miso_oe, 0);
      tk(6);
      chk(rx_full == 1'b0, "R8 partial byte dropped", rx_full, 0);
      for (int k = 0; k < 16; k++) begin sck_drv = ~sck_drv; tk(4); end
      chk(rx_full == 1'b0, "R8 edges ignored when deselected", rx_full, 0);
      exp_q.push_back(8'h81);
      ss_drv = 1'b0;
      tk(HB);
      s_xfer(8'h81, 8, 1'b0, 1'b0, cap);
      chk(cap == 8'h5A, "R8 transmit byte restarted", cap, 8'h5A);
      ss_drv = 1'b1;
      tk(4);

      // slave cpha 1, cpol 1, two bytes under one select
      wr_ctrl(6'b001101);
      sck_drv = 1'b1;
      tk(4);
      wr_data(8'hA5);
      ss_drv = 1'b0;
      tk(HB);
      wr_data(8'h96);
      exp_q.push_back(8'h33);
      s_xfer(8'h33, 8, 1'b1, 1'b1, cap);
      chk(cap == 8'hA5, "R9 first byte", cap, 8'hA5);
      exp_q.push_back(8'hCC);
      s_xfer(8'hCC, 8, 1'b1, 1'b1, cap);
      chk(cap == 8'h96, "R9 second byte from buffer", cap, 8'h96);
      ss_drv = 1'b1;
      tk(10);
      chk(exp_q.size() == 0, "R6 all bytes received", exp_q.size(), 0);
      report();
   end
endmodule